// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Frame Store

This block is the receive half of a small memory-mapped Ethernet MAC. Frames arrive one byte per cycle on a streaming input (`rx_valid`, `rx_data`, `rx_last`). The block holds the first six bytes until the destination address is known. It then checks that address against the station address. A frame that passes the check goes into one of two on-chip receive buffers. When the frame ends, that buffer is marked full and an interrupt pulse may be raised. If alternating mode is on, the write pointer then moves to the other buffer.

Software reads the stored frames through a 32-bit register port with a one-cycle read latency. It releases a buffer by writing that buffer's control word with the full flag cleared. While the selected buffer is still full, any frame that passes the filter is dropped as lost. Frames that fail the filter, frames shorter than six bytes and frames that are dropped all leave the buffer contents and the pointer as they were.

The frame path is a five-state machine:
- **IDLE** waits for a first byte. It moves to **HDR** on a byte that is not also last.
- **HDR** collects destination bytes 1 to 5. On byte 5 it goes to **STORE** if the frame is accepted and to **SKIP** if it is not.
- **HDR** goes back to IDLE if the frame ends early. If a six-byte frame is accepted it goes to **FLUSH**.
- **STORE** writes payload words and returns to IDLE on the last byte.
- **SKIP** discards bytes until the last byte, then returns to IDLE.
- **FLUSH** writes the second word of a six-byte frame and completes it. Like IDLE, it can take the first byte of a new frame in the same cycle.

Top module: `erx_pingpong_rx`

## Requirements
- R1: After reset, buffer 0 is selected, both control words and the enable word read 0, `rx_ready` is 1 and `irq_pulse` is 0.
- R2: A frame is accepted when bit 7 of its first byte is 1 (group bypass), or when its first six bytes equal `station_mac`, with `station_mac[47:40]` compared against the first byte. Any other frame, and any frame shorter than six bytes, is discarded without changing stored data, control words or the pointer.
- R3: If bit 0 (full flag) of the selected buffer's control word is 1 when the sixth byte arrives, an otherwise accepted frame is dropped. It changes no data, raises no interrupt and does not move the pointer.
- R4: Byte k of an accepted frame is stored at byte offset 4*(k/4) from the buffer base, in bits 8*(k%4)+7:8*(k%4). Lanes of the last word that lie past the end of the frame read 0. The buffer's full flag becomes 1 once the frame completes.
- R5: When a frame completes, `irq_pulse` is high for exactly one cycle if bit 3 of that buffer's control word is 1 and bit 31 of the enable word (offset 0x7F8) is 1. Otherwise it stays low.
- R6: With `pingpong_en`=1 the pointer toggles after every completed frame. With `pingpong_en`=0 it does not move, so buffer 0 is always used.
- R7: Bytes past the 2044-byte data area (511 words) are ignored, so a long frame never changes a control word.
- R8: A write to a control word (0x17FC for buffer 0, 0x1FFC for buffer 1) or to the enable word stores all 32 bits, and the stored value reads back. Writing the full flag as 0 frees the buffer. `rx_ready` is the inverse of the selected buffer's full flag.
- R9: `bus_rdata` returns the value at the address presented one cycle earlier. Data words sit at 0x1000 + 4*i (buffer 0) and 0x1800 + 4*i (buffer 1). Unmapped or misaligned addresses read 0, and writes to data words or unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_mac | input | 48 | Station address; bits 47:40 are compared with the first byte |
| pingpong_en | input | 1 | 1 = alternate buffers after each stored frame |
| rx_valid | input | 1 | A frame byte is present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_ready | output | 1 | Selected buffer is free |
| bus_addr | input | 13 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| irq_pulse | output | 1 | One-cycle interrupt on frame completion |

## Verification
The bench goes after these corner cases:
- **Six-byte frame.** It takes the FLUSH path. A design that forgot the second word, or wrote it to the wrong index, would return stale bytes 4 and 5.
- **Frame into a full buffer.** A design that checked the full flag at the wrong time, or not at all, would overwrite unread data or fire an interrupt.
- **Mismatched unicast and short frames.** Without filtering before any storage, these would corrupt the buffer or move the pointer.
- **Long frame.** One longer than the data area would overwrite the control word if truncation were missing.
- **Alternating mode off.** If this mode were ignored, the frame would land in buffer 1.
- **Enable word cleared.** A design that ignored the enable word would still pulse the interrupt.

// File: rtl/erx_pkg.sv
package erx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_STORE,
        ST_FLUSH,
        ST_SKIP
    } erx_state_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_MEM,
        RD_REG
    } erx_rd_kind_e;

    localparam int DA_BYTES = 6;

endpackage

// File: rtl/erx_da_filter.sv
module erx_da_filter
    import erx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  logic [2:0]  cap_idx,
    input  logic [7:0]  cap_byte,
    input  logic [47:0] station_mac,
    output logic        da_hit
);

    localparam int HELD = DA_BYTES - 1;

    logic [7:0] hdr_q [HELD];

    for (genvar g = 0; g < HELD; g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hdr_q[g] <= 8'h00;
            end else if (cap_en && cap_idx == 3'(g)) begin
                hdr_q[g] <= cap_byte;
            end
        end
    end

    // Valid while the sixth byte is on cap_byte.
    logic [47:0] da_full;
    assign da_full = {hdr_q[0], hdr_q[1], hdr_q[2], hdr_q[3], hdr_q[4], cap_byte};
    assign da_hit  = hdr_q[0][7] || (da_full == station_mac);

endmodule

// File: rtl/erx_buf_ram.sv
module erx_buf_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/erx_frame_fsm.sv
module erx_frame_fsm
    import erx_pkg::*;
#(
    parameter int CAP_WORDS = 511,
    parameter int IDX_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             da_hit,
    input  logic             buf_full,
    output logic             hdr_en,
    output logic [2:0]       hdr_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_word,
    output logic             commit
);

    localparam int CAP_BYTES = CAP_WORDS * 4;
    localparam int CNT_W     = $clog2(CAP_BYTES + 1);
    localparam logic [CNT_W-1:0] CAP_C    = CNT_W'(CAP_BYTES);
    localparam logic [CNT_W-1:0] DECIDE_C = CNT_W'(DA_BYTES - 1);
    localparam logic [CNT_W-1:0] W0_C     = CNT_W'(3);

    erx_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      asm_q;
    logic [31:0]      w0_q;

    logic             first;
    logic [CNT_W-1:0] pos;
    logic [1:0]       lane;
    logic [31:0]      asm_next;
    logic             decide;
    logic             accept;

    assign first   = (state_q == ST_IDLE) || (state_q == ST_FLUSH);
    assign pos     = first ? '0 : cnt_q;
    assign lane    = pos[1:0];
    assign decide  = (state_q == ST_HDR) && rx_valid && (cnt_q == DECIDE_C);
    assign accept  = decide && da_hit && !buf_full;
    assign hdr_en  = rx_valid && (first || state_q == ST_HDR);
    assign hdr_idx = pos[2:0];

    always_comb begin
        asm_next = (lane == 2'd0) ? 32'h0 : asm_q;
        asm_next[{lane, 3'b000} +: 8] = rx_data;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FLUSH: begin
                if (rx_valid && !rx_last) state_d = ST_HDR;
                else                      state_d = ST_IDLE;
            end
            ST_HDR: begin
                if (rx_valid) begin
                    if (rx_last)     state_d = accept ? ST_FLUSH : ST_IDLE;
                    else if (decide) state_d = accept ? ST_STORE : ST_SKIP;
                end
            end
            ST_STORE: if (rx_valid && rx_last) state_d = ST_IDLE;
            ST_SKIP:  if (rx_valid && rx_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_word = asm_next;
        commit  = 1'b0;
        unique case (state_q)
            ST_FLUSH: begin
                wr_en   = 1'b1;
                wr_idx  = IDX_W'(1);
                wr_word = asm_q;
                commit  = 1'b1;
            end
            ST_HDR: begin
                if (accept) begin
                    wr_en   = 1'b1;
                    wr_idx  = '0;
                    wr_word = w0_q;
                end
            end
            ST_STORE: begin
                if (rx_valid && pos < CAP_C && (lane == 2'd3 || rx_last)) begin
                    wr_en  = 1'b1;
                    wr_idx = IDX_W'(pos[CNT_W-1:2]);
                end
                commit = rx_valid && rx_last;
            end
            default: ;
        endcase
    end

    // Byte assembly and position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            asm_q <= '0;
            w0_q  <= '0;
        end else if (rx_valid) begin
            asm_q <= asm_next;
            cnt_q <= (pos == CAP_C) ? CAP_C : pos + CNT_W'(1);
            if (pos == W0_C) w0_q <= asm_next;
        end
    end

    p_wr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(CAP_WORDS)))
        else $error("write index past data area");

    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit)
        else $error("two completions back to back");

endmodule

// File: rtl/erx_pingpong_rx.sv
module erx_pingpong_rx
    import erx_pkg::*;
#(
    parameter int REGION_LOG2 = 11,
    parameter int GIE_OFFSET  = 'h7F8,
    localparam int ADDR_W     = REGION_LOG2 + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       station_mac,
    input  logic              pingpong_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_pulse
);

    localparam int IDX_W     = REGION_LOG2 - 2;
    localparam int CAP_WORDS = (1 << IDX_W) - 1;
    localparam int MEM_AW    = IDX_W + 1;
    localparam logic [ADDR_W-1:0] GIE_A = ADDR_W'(GIE_OFFSET);

    logic             sel_q;
    logic [31:0]      ctrl_q [2];
    logic [31:0]      gie_q;
    logic             irq_q;

    logic             hdr_en;
    logic [2:0]       hdr_idx;
    logic             da_hit;
    logic             buf_full;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0]      wr_word;
    logic             commit;
    logic [31:0]      mem_rd;

    assign buf_full  = ctrl_q[sel_q][0];
    assign rx_ready  = !buf_full;
    assign irq_pulse = irq_q;

    erx_da_filter i_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (hdr_en),
        .cap_idx     (hdr_idx),
        .cap_byte    (rx_data),
        .station_mac (station_mac),
        .da_hit      (da_hit)
    );

    erx_frame_fsm #(
        .CAP_WORDS (CAP_WORDS),
        .IDX_W     (IDX_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last),
        .da_hit   (da_hit),
        .buf_full (buf_full),
        .hdr_en   (hdr_en),
        .hdr_idx  (hdr_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .commit   (commit)
    );

    erx_buf_ram #(
        .AW (MEM_AW)
    ) i_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr ({sel_q, wr_idx}),
        .wr_data (wr_word),
        .rd_addr ({bus_addr[REGION_LOG2], bus_addr[REGION_LOG2-1:2]}),
        .rd_data (mem_rd)
    );

    // Address decode
    logic aligned, in_rx, top_word, is_ctrl, is_data, is_gie, buf_b;
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_rx    = bus_addr[ADDR_W-1];
    assign top_word = &bus_addr[REGION_LOG2-1:2];
    assign is_ctrl  = in_rx && aligned && top_word;
    assign is_data  = in_rx && aligned && !top_word;
    assign is_gie   = (bus_addr == GIE_A);
    assign buf_b    = bus_addr[REGION_LOG2];

    // Per-buffer control words; a frame completion sets the full flag
    for (genvar b = 0; b < 2; b++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[b] <= '0;
            end else begin
                if (bus_wen && is_ctrl && buf_b == 1'(b)) ctrl_q[b] <= bus_wdata;
                if (commit && sel_q == 1'(b))             ctrl_q[b][0] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= '0;
            sel_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (bus_wen && is_gie) gie_q <= bus_wdata;
            irq_q <= commit && ctrl_q[sel_q][3] && gie_q[31];
            if (commit) sel_q <= sel_q ^ pingpong_en;
        end
    end

    // Read path: one cycle latency
    erx_rd_kind_e rd_kind_q;
    logic [31:0]  rd_reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_kind_q <= RD_ZERO;
            rd_reg_q  <= '0;
        end else begin
            if (is_data)              rd_kind_q <= RD_MEM;
            else if (is_ctrl || is_gie) rd_kind_q <= RD_REG;
            else                      rd_kind_q <= RD_ZERO;
            rd_reg_q <= is_ctrl ? ctrl_q[buf_b] : gie_q;
        end
    end

    always_comb begin
        unique case (rd_kind_q)
            RD_MEM:  bus_rdata = mem_rd;
            RD_REG:  bus_rdata = rd_reg_q;
            default: bus_rdata = '0;
        endcase
    end

    p_irq_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(commit))
        else $error("interrupt without completion");

    p_full_only_by_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q[0][0]) && !$past(bus_wen)) |-> $past(commit))
        else $error("full flag set without a frame");

    p_sel_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pingpong_en && !sel_q) |=> !sel_q)
        else $error("pointer moved with alternation off");

    p_no_drop_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !$past(bus_wen)) |-> !$past(buf_full))
        else $error("frame completed into a full buffer");

endmodule

// File: tb/test_erx_pingpong_rx.sv
module test_erx_pingpong_rx;

    localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;
    localparam int CAP = 2044;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pingpong_en = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic [12:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    always #10 clk = ~clk;

    erx_pingpong_rx i_erx_pingpong_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .station_mac (MAC),
        .pingpong_en (pingpong_en),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .rx_ready    (rx_ready),
        .bus_addr    (bus_addr),
        .bus_wen     (bus_wen),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_pulse   (irq_pulse)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard: reads push expectations, the monitor pops and compares
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_stb = 1'b0;
    logic        pend = 1'b0;

    always @(posedge clk) pend <= rd_stb;

    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_rdata === e, t, bus_rdata, e);
        end
    end

    task automatic bus_read(input logic [12:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        rd_stb = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Reference model
    logic [7:0]  frm [$];
    logic [7:0]  img [2][CAP];
    int          img_len [2] = '{0, 0};
    logic [31:0] m_ctrl [2] = '{32'h0, 32'h0};
    logic [31:0] m_gie = 32'h0;
    bit          m_sel = 0;

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
        if (a == 13'h17FC) m_ctrl[0] = d;
        if (a == 13'h1FFC) m_ctrl[1] = d;
        if (a == 13'h07F8) m_gie = d;
    endtask

    function automatic logic [12:0] ctrl_addr(input int b);
        return (b == 0) ? 13'h17FC : 13'h1FFC;
    endfunction

    function automatic logic [31:0] exp_word(input int b, input int w);
        logic [31:0] r = '0;
        for (int l = 0; l < 4; l++) begin
            if (4 * w + l < img_len[b]) r[8*l +: 8] = img[b][4*w+l];
        end
        return r;
    endfunction

    task automatic mk_frame(input logic [47:0] da, input int len, input logic [7:0] seed);
        frm.delete();
        for (int i = 0; i < len; i++) begin
            if (i < 6) frm.push_back(da[47 - 8*i -: 8]);
            else       frm.push_back(seed ^ 8'(i * 7));
        end
    endtask

    task automatic send_frame(input string req);
        int  len;
        bit  hit;
        bit  exp_irq;
        int  pulses;
        len = frm.size();
        hit = (len >= 6) && (frm[0][7] || ({frm[0], frm[1], frm[2], frm[3], frm[4], frm[5]} == MAC));
        exp_irq = 0;
        if (hit && !m_ctrl[m_sel][0]) begin
            img_len[m_sel] = (len > CAP) ? CAP : len;
            for (int i = 0; i < img_len[m_sel]; i++) img[m_sel][i] = frm[i];
            m_ctrl[m_sel][0] = 1'b1;
            exp_irq = m_ctrl[m_sel][3] && m_gie[31];
            m_sel = m_sel ^ pingpong_en;
        end
        pulses = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (irq_pulse) pulses++;
            rx_valid = 1'b1;
            rx_data  = frm[i];
            rx_last  = (i == len - 1);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_last  = 1'b0;
            if (irq_pulse) pulses++;
        end
        chk(pulses == (exp_irq ? 1 : 0), {req, " irq pulse count"}, 32'(pulses), exp_irq ? 32'd1 : 32'd0);
        chk(rx_ready == !m_ctrl[m_sel][0], {req, " rx_ready"}, 32'(rx_ready), 32'(!m_ctrl[m_sel][0]));
    endtask

    task automatic check_buf(input int b, input int w0, input int w1, input string req);
        for (int w = w0; w <= w1; w++) begin
            bus_read(13'h1000 + 13'(b * 'h800) + 13'(4 * w), exp_word(b, w), req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(rx_ready == 1'b1, "R1 rx_ready", 32'(rx_ready), 32'd1);
        chk(irq_pulse == 1'b0, "R1 irq", 32'(irq_pulse), 32'd0);
        bus_read(13'h17FC, 32'h0, "R1 ctrl0");
        bus_read(13'h1FFC, 32'h0, "R1 ctrl1");
        bus_read(13'h07F8, 32'h0, "R1 enable word");

        // R8 register write and readback
        bus_write(13'h07F8, 32'h8000_0000);
        bus_write(13'h17FC, 32'h0000_0008);
        bus_write(13'h1FFC, 32'hA5A0_0008);
        bus_read(13'h07F8, 32'h8000_0000, "R8 enable readback");
        bus_read(13'h1FFC, 32'hA5A0_0008, "R8 ctrl1 readback");
        // R9 unmapped and misaligned reads
        bus_read(13'h0000, 32'h0, "R9 unmapped read");
        bus_read(13'h1002, 32'h0, "R9 misaligned read");

        // R4 unicast match into buffer 0, R5 irq, R6 toggle
        mk_frame(MAC, 10, 8'hA0);
        send_frame("R4 R5 unicast frame");
        check_buf(0, 0, 2, "R4 buffer0 data");
        bus_read(13'h17FC, m_ctrl[0], "R4 full flag buf0");

        // R2 group bypass with a six-byte frame into buffer 1 (FLUSH path)
        mk_frame(48'h81_99_88_77_66_55, 6, 8'h00);
        send_frame("R2 group six-byte frame");
        check_buf(1, 0, 1, "R2 buffer1 data");
        bus_read(13'h1FFC, m_ctrl[1], "R6 full flag buf1");

        // R3 drop when the selected buffer (0) is full
        mk_frame(MAC, 12, 8'h3C);
        send_frame("R3 frame into full buffer");
        check_buf(0, 0, 2, "R3 buffer0 unchanged");

        // R8 free buffer 0, then R2 mismatched unicast and short frame
        bus_write(13'h17FC, 32'h0000_0008);
        chk(rx_ready == 1'b1, "R8 rx_ready after free", 32'(rx_ready), 32'd1);
        mk_frame(48'h02_11_22_33_44_56, 9, 8'h11);
        send_frame("R2 mismatched unicast");
        mk_frame(48'hFF_FF_FF_FF_00_00, 4, 8'h00);
        send_frame("R2 short frame");
        bus_read(13'h17FC, 32'h0000_0008, "R2 ctrl0 still free");
        check_buf(0, 0, 2, "R2 buffer0 unchanged");

        // R9 data writes ignored
        bus_write(13'h1000, 32'hDEAD_BEEF);
        check_buf(0, 0, 0, "R9 data write ignored");

        // R6 alternation off: buffer 0 used twice
        bus_write(13'h1FFC, 32'h0000_0008);
        pingpong_en = 1'b0;
        mk_frame(MAC, 8, 8'h50);
        send_frame("R6 no alternation first");
        bus_write(13'h17FC, 32'h0000_0008);
        mk_frame(48'hC0_01_02_03_04_05, 11, 8'h77);
        send_frame("R6 no alternation second");
        check_buf(0, 0, 2, "R6 buffer0 holds second frame");
        bus_read(13'h1FFC, 32'h0000_0008, "R6 buffer1 untouched");

        // R7 truncation of a long frame
        bus_write(13'h17FC, 32'h0000_0008);
        mk_frame(MAC, 2100, 8'h2D);
        send_frame("R7 long frame");
        check_buf(0, 0, 1, "R7 long frame head");
        check_buf(0, 509, 510, "R7 long frame tail");
        bus_read(13'h17FC, 32'h0000_0009, "R7 ctrl0 intact");

        // R5 enable word cleared: full flag set, no pulse
        bus_write(13'h07F8, 32'h0);
        bus_write(13'h17FC, 32'h0000_0008);
        mk_frame(MAC, 7, 8'h0F);
        send_frame("R5 enable cleared");
        bus_read(13'h17FC, 32'h0000_0009, "R5 full flag without irq");
        check_buf(0, 0, 1, "R4 seven-byte frame");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule